// File: doc/BRIEF.md
# Nonvolatile Program and Erase Sequencer

This block sits between a bus-side command decoder and a byte-programmable nonvolatile array. The decoder hands it one request at a time: either a single-byte program (address plus data) or a page erase (any address inside the page). The block checks that the request lies inside the nonvolatile window, latches it, and holds `busy` for a fixed number of clock cycles while the operation runs. The bus side uses `busy` to stretch its clock. At the last busy cycle, the block issues a one-cycle strobe to the array.

A program request also carries the number of bytes still to follow in the current block write. This lets the block refuse the whole tail of a block that would run past the top of the window. Block writes may start anywhere and run straight across page boundaries; the address is never wrapped.

An erase always acts on a whole 32-byte page. The five lowest address bits are dropped, and the array is told to fill the page with 0xFF. A refused request never reaches the array. Instead it raises a sticky error flag that only reset clears.

Top module: `nvseq_top`

## Requirements
- R1: After reset `req_ready` is high, `busy`, `err_range`, `nv_prog_stb` and `nv_erase_stb` are low.
- R2: An accepted, in-range program request raises `busy` on the next cycle and holds it for exactly PROG_CYCLES cycles, with `req_ready` low for that whole time.
- R3: An accepted program produces exactly one `nv_prog_stb` pulse, in the last busy cycle, with `nv_addr`/`nv_data` equal to the address and data captured when the request was accepted.
- R4: While `busy` is high, `req_ready` is low and requests are ignored: no second operation starts, and the running one keeps its captured address and data.
- R5: An accepted erase (`req_erase`=1) holds `busy` for exactly ERASE_CYCLES cycles and produces one `nv_erase_stb` pulse in its last busy cycle, with `nv_addr` equal to the request address with bits [4:0] cleared and `nv_data` = 0xFF.
- R6: A request whose address (page base for an erase) is below 0xF800 or above 0xFBFF is refused: `busy` stays low, no strobe is issued, and `err_range` is high from the next cycle.
- R7: A program with `req_rem` = k (number of bytes still to follow, 0..31) is refused when address + k exceeds 0xFBFF and accepted when it equals 0xFBFF.
- R8: `err_range` stays high until reset, and later in-range requests still run normally.
- R9: Consecutive programs to 0xF81F and 0xF820 strobe exactly those addresses, and 0xF820 is accepted without any page wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_erase | input | 1 | 1 = page erase, 0 = byte program |
| req_addr | input | 16 | Target address |
| req_data | input | 8 | Byte to program |
| req_rem | input | 5 | Bytes still to follow in the block write (program only) |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| busy | output | 1 | Operation in progress; bus clock must be stretched |
| err_range | output | 1 | Sticky out-of-range flag |
| nv_prog_stb | output | 1 | One-cycle program command to the array |
| nv_erase_stb | output | 1 | One-cycle page erase command to the array |
| nv_addr | output | 16 | Byte address, or page base for an erase |
| nv_data | output | 8 | Byte to write, 0xFF on erase |

## Verification
The hardest case to reach is a request that is held valid, with a different address, all through a running operation. It must not disturb the captured job or start a second one once `busy` drops. The stimulus reaches this case by accepting a program and then, on the very next falling edge, switching the address and data while keeping `req_valid` high for several busy cycles. The bench then counts every strobe until well after `busy` falls. Two boundary pairs are also exercised: 0xFBFF exactly filled versus overrun by one byte, and the last byte of one page followed by the first byte of the next.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int NV_ADDR_W  = 16;
    localparam int NV_DATA_W  = 8;
    localparam int NV_REM_W   = 5;
    localparam int NV_PAGE_LG = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } nv_state_e;

    typedef struct packed {
        logic                 erase;
        logic [NV_ADDR_W-1:0] addr;
        logic [NV_DATA_W-1:0] data;
    } nv_job_t;

    function automatic logic [NV_ADDR_W-1:0] page_base(input logic [NV_ADDR_W-1:0] a);
        logic [NV_ADDR_W-1:0] m;
        m = '1;
        m[NV_PAGE_LG-1:0] = '0;
        return a & m;
    endfunction

    function automatic logic [NV_ADDR_W:0] span_end(input logic [NV_ADDR_W-1:0] a,
                                                    input logic [NV_REM_W-1:0]  r);
        return {1'b0, a} + {{(NV_ADDR_W+1-NV_REM_W){1'b0}}, r};
    endfunction

endpackage

// File: rtl/nvseq_range.sv
module nvseq_range
    import nvseq_pkg::*;
#(
    parameter logic [NV_ADDR_W-1:0] WIN_LO = 16'hF800,
    parameter logic [NV_ADDR_W-1:0] WIN_HI = 16'hFBFF
) (
    input  logic                 erase,
    input  logic [NV_ADDR_W-1:0] addr,
    input  logic [NV_REM_W-1:0]  rem,
    output logic                 ok
);
    logic [NV_ADDR_W-1:0] base;
    logic [NV_ADDR_W:0]   last;
    logic                 prog_ok;
    logic                 erase_ok;

    always_comb begin
        base     = page_base(addr);
        last     = span_end(addr, rem);
        prog_ok  = (addr >= WIN_LO) && (last <= {1'b0, WIN_HI});
        erase_ok = (base >= WIN_LO) && (base <= WIN_HI);
        ok       = erase ? erase_ok : prog_ok;
    end
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
    import nvseq_pkg::*;
#(
    parameter int                   PROG_CYCLES  = 12500,
    parameter int                   ERASE_CYCLES = 25000,
    parameter logic [NV_ADDR_W-1:0] WIN_LO       = 16'hF800,
    parameter logic [NV_ADDR_W-1:0] WIN_HI       = 16'hFBFF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_erase,
    input  logic [NV_ADDR_W-1:0] req_addr,
    input  logic [NV_DATA_W-1:0] req_data,
    input  logic [NV_REM_W-1:0]  req_rem,
    output logic                 req_ready,
    output logic                 busy,
    output logic                 err_range,
    output logic                 nv_prog_stb,
    output logic                 nv_erase_stb,
    output logic [NV_ADDR_W-1:0] nv_addr,
    output logic [NV_DATA_W-1:0] nv_data
);
    localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW      = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

    nv_state_e     state_q;
    nv_job_t       job_q;
    logic          err_q;
    logic          accept;
    logic          in_range;
    logic          start;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_done;

    nvseq_range #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) range_i (
        .erase (req_erase),
        .addr  (req_addr),
        .rem   (req_rem),
        .ok    (in_range)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign start     = accept && in_range;
    assign t_load    = start;
    assign t_val     = req_erase ? ERASE_LOAD : PROG_LOAD;

    nvseq_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q     <= req_erase ? ST_ERASE : ST_PROG;
                        job_q.erase <= req_erase;
                        job_q.addr  <= req_erase ? page_base(req_addr) : req_addr;
                        job_q.data  <= req_erase ? '1 : req_data;
                    end else if (accept) begin
                        err_q <= 1'b1;
                    end
                end
                ST_PROG, ST_ERASE: begin
                    if (t_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign err_range    = err_q;
    assign nv_prog_stb  = (state_q == ST_PROG)  && t_done;
    assign nv_erase_stb = (state_q == ST_ERASE) && t_done;
    assign nv_addr      = job_q.addr;
    assign nv_data      = job_q.data;
endmodule

// File: rtl/nvseq_checker.sv
module nvseq_checker
    import nvseq_pkg::*;
#(
    parameter int                   PROG_CYCLES  = 12500,
    parameter int                   ERASE_CYCLES = 25000,
    parameter logic [NV_ADDR_W-1:0] WIN_LO       = 16'hF800,
    parameter logic [NV_ADDR_W-1:0] WIN_HI       = 16'hFBFF
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_erase,
    input logic [NV_ADDR_W-1:0] req_addr,
    input logic [NV_REM_W-1:0]  req_rem,
    input logic                 req_ready,
    input logic                 busy,
    input logic                 err_range,
    input logic                 nv_prog_stb,
    input logic                 nv_erase_stb,
    input logic [NV_ADDR_W-1:0] nv_addr,
    input logic [NV_DATA_W-1:0] nv_data
);
    logic [31:0]        run_len;
    logic               bad_req;
    logic [NV_ADDR_W:0] top_byte;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1;
    end

    always_comb begin
        top_byte = {1'b0, req_addr} + {12'b0, req_rem};
        if (req_erase)
            bad_req = ({req_addr[15:5], 5'b0} < WIN_LO) || ({req_addr[15:5], 5'b0} > WIN_HI);
        else
            bad_req = (req_addr < WIN_LO) || (top_byte > {1'b0, WIN_HI});
    end

    // R2
    prog_len_chk: assert property (@(posedge clk) disable iff (rst)
        nv_prog_stb |-> (run_len == 32'(PROG_CYCLES - 1)));

    // R5
    erase_len_chk: assert property (@(posedge clk) disable iff (rst)
        nv_erase_stb |-> (run_len == 32'(ERASE_CYCLES - 1)) && (nv_addr[4:0] == 5'd0) && (nv_data == 8'hFF));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nv_prog_stb, nv_erase_stb}));

    // R4
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(nv_addr));

    // R6
    refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && bad_req) |=> (!busy && err_range));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_range |=> err_range);
endmodule

bind nvseq_top nvseq_checker #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .WIN_LO       (WIN_LO),
    .WIN_HI       (WIN_HI)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_erase    (req_erase),
    .req_addr     (req_addr),
    .req_rem      (req_rem),
    .req_ready    (req_ready),
    .busy         (busy),
    .err_range    (err_range),
    .nv_prog_stb  (nv_prog_stb),
    .nv_erase_stb (nv_erase_stb),
    .nv_addr      (nv_addr),
    .nv_data      (nv_data)
);

// File: tb/nvseq_top_tb_top.sv
module nvseq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_N  = 6;
    localparam int ERASE_N = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_erase = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [4:0]  req_rem = '0;
    logic        req_ready, busy, err_range, nv_prog_stb, nv_erase_stb;
    logic [15:0] nv_addr;
    logic [7:0]  nv_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvseq_top #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_data(req_data), .req_rem(req_rem),
        .req_ready(req_ready), .busy(busy), .err_range(err_range),
        .nv_prog_stb(nv_prog_stb), .nv_erase_stb(nv_erase_stb),
        .nv_addr(nv_addr), .nv_data(nv_data)
    );

    task automatic chk(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Presents one request; returns at the falling edge after the accepting edge.
    task automatic issue(input bit ers, input logic [15:0] a, input logic [7:0] d, input logic [4:0] r);
        req_valid = 1'b1;
        req_erase = ers;
        req_addr  = a;
        req_data  = d;
        req_rem   = r;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic observe(input bit ok, input bit ers, input logic [15:0] ea,
                           input logic [7:0] ed, input string tag);
        int nb = 0, ns = 0, nw = 0, nrdy = 0;
        int dur = ers ? ERASE_N : PROG_N;
        logic [15:0] ga = '0;
        logic [7:0]  gd = '0;
        bit er = err_range;
        for (int i = 0; i < dur + 4; i++) begin
            if (busy) nb++;
            if (busy && req_ready) nrdy++;
            if ((ers ? nv_erase_stb : nv_prog_stb)) begin ns++; ga = nv_addr; gd = nv_data; end
            if ((ers ? nv_prog_stb : nv_erase_stb)) nw++;
            @(negedge clk);
        end
        if (ok) begin
            chk(nb == dur, tag, $sformatf("busy cycles actual %0d expected %0d", nb, dur));
            chk(nrdy == 0, tag, $sformatf("ready while busy actual %0d expected 0", nrdy));
            chk(ns == 1 && nw == 0, tag, $sformatf("strobes actual %0d/%0d expected 1/0", ns, nw));
            chk(ga == ea && gd == ed, tag,
                $sformatf("array cmd actual %h/%h expected %h/%h", ga, gd, ea, ed));
        end else begin
            chk(nb == 0 && ns == 0 && nw == 0, tag,
                $sformatf("refused op activity busy %0d strobes %0d/%0d expected 0", nb, ns, nw));
            chk(er == 1'b1, tag, $sformatf("err_range actual %b expected 1", er));
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(req_ready && !busy && !err_range && !nv_prog_stb && !nv_erase_stb, "R1",
            $sformatf("ready/busy/err/stb actual %b%b%b%b%b expected 10000",
                      req_ready, busy, err_range, nv_prog_stb, nv_erase_stb));
    endtask

    task automatic t_prog_basic();
        issue(1'b0, 16'hF805, 8'h3C, 5'd0);
        observe(1'b1, 1'b0, 16'hF805, 8'h3C, "R2 R3 single program");
        issue(1'b0, 16'hFA00, 8'hA5, 5'd31);
        observe(1'b1, 1'b0, 16'hFA00, 8'hA5, "R3 block head program");
        chk(!err_range, "R3", $sformatf("err_range actual %b expected 0", err_range));
    endtask

    task automatic t_busy_ignore();
        int ns = 0, nb = 0;
        logic [15:0] ga = '0;
        logic [7:0]  gd = '0;
        req_valid = 1'b1; req_erase = 1'b0; req_addr = 16'hF910; req_data = 8'h11; req_rem = 5'd0;
        @(posedge clk);
        @(negedge clk);
        req_addr = 16'hF9F0; req_data = 8'hEE; req_erase = 1'b1;
        for (int i = 0; i < PROG_N + 8; i++) begin
            if (i == 3) req_valid = 1'b0;
            if (i < 3) chk(!req_ready, "R4", $sformatf("ready during busy actual %b expected 0", req_ready));
            if (busy) nb++;
            if (nv_prog_stb || nv_erase_stb) begin ns++; ga = nv_addr; gd = nv_data; end
            @(negedge clk);
        end
        chk(nb == PROG_N, "R4", $sformatf("busy cycles actual %0d expected %0d", nb, PROG_N));
        chk(ns == 1 && ga == 16'hF910 && gd == 8'h11, "R4",
            $sformatf("strobes %0d cmd actual %h/%h expected 1 F910/11", ns, ga, gd));
    endtask

    task automatic t_erase();
        issue(1'b1, 16'hFB3F, 8'h00, 5'd0);
        observe(1'b1, 1'b1, 16'hFB20, 8'hFF, "R5 erase page FB20");
        issue(1'b1, 16'hF800, 8'h00, 5'd7);
        observe(1'b1, 1'b1, 16'hF800, 8'hFF, "R5 erase page F800");
    endtask

    task automatic t_page_cross();
        issue(1'b0, 16'hF81F, 8'h01, 5'd1);
        observe(1'b1, 1'b0, 16'hF81F, 8'h01, "R9 last byte of page");
        issue(1'b0, 16'hF820, 8'h02, 5'd0);
        observe(1'b1, 1'b0, 16'hF820, 8'h02, "R9 first byte of next page");
    endtask

    task automatic t_fit_edge();
        issue(1'b0, 16'hFBF0, 8'h5A, 5'd15);
        observe(1'b1, 1'b0, 16'hFBF0, 8'h5A, "R7 block ends at FBFF");
        chk(!err_range, "R7", $sformatf("err_range actual %b expected 0", err_range));
        issue(1'b0, 16'hFBF0, 8'h5A, 5'd16);
        observe(1'b0, 1'b0, 16'h0, 8'h0, "R7 block overruns FBFF");
    endtask

    task automatic t_range();
        issue(1'b0, 16'hF7FF, 8'h77, 5'd0);
        observe(1'b0, 1'b0, 16'h0, 8'h0, "R6 program below window");
        issue(1'b0, 16'hFC00, 8'h77, 5'd0);
        observe(1'b0, 1'b0, 16'h0, 8'h0, "R6 program above window");
        issue(1'b1, 16'hFC1F, 8'h00, 5'd0);
        observe(1'b0, 1'b1, 16'h0, 8'h0, "R6 erase above window");
    endtask

    task automatic t_sticky();
        issue(1'b0, 16'hF900, 8'h9C, 5'd0);
        observe(1'b1, 1'b0, 16'hF900, 8'h9C, "R8 legal op after error");
        chk(err_range, "R8", $sformatf("err_range actual %b expected 1", err_range));
        do_reset();
        chk(!err_range, "R8", $sformatf("err_range after reset actual %b expected 0", err_range));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: cycles actual %0d expected below 20000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_prog_basic();
        t_busy_ignore();
        t_erase();
        t_page_cross();
        t_fit_edge();
        t_range();
        t_sticky();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule